// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block turns single-byte host writes into latch cycles on a NAND flash bus. A host write flagged as a command produces one command-latch cycle, and a write flagged as an address produces one address-latch cycle. Each cycle drives the byte on the I/O bus, raises the matching latch line and pulses the write strobe low. Writing the byte 0xFF as a command is how the host resets the flash.

Every phase length comes from a packed timing word that the block samples when it accepts a host write. There is no fixed timing parameter. The phases of a cycle are a chip-enable lead time, the strobe-low time, the strobe-high time and a bus turnaround time. After each command cycle, a busy-delay counter hides the flash ready/busy line until the flash has had time to pull it low. After that delay the block reports the synchronized line to the host as `nand_ready`.

The host holds `host_wr` and its data steady until `host_ready` is high at a clock edge. Writes that arrive while a cycle runs are therefore held back, never lost.

Top module: `nand_cycle_seq`

## Requirements
- R1: A command write (`host_addr`=0) produces exactly one strobe-low pulse with `nand_cle`=1, `nand_ale`=0 and `nand_io` equal to the written byte. The byte 0xFF is issued the same way as the flash reset command.
- R2: An address write (`host_addr`=1) produces exactly one strobe-low pulse with `nand_ale`=1, `nand_cle`=0 and `nand_io` equal to the written byte.
- R3: After acceptance, the latch line and data are held for eff(timing[25:24]) clocks with `nand_we_n` high before the strobe falls.
- R4: `nand_we_n` stays low for eff(timing[3:0]) clocks. It then stays high for eff(timing[7:4]) clocks with the latch line and `nand_io` unchanged.
- R5: After the strobe-high phase, both latch lines are low for eff(timing[18:16]) clocks before `host_ready` returns high.
- R6: A timing field of 0 counts as 1 clock. In all other cases eff(x)=x.
- R7: `host_ready` is high only when no cycle is in progress. A write held on `host_wr` while a cycle runs is issued after that cycle, in order, and is not dropped.
- R8: On the clock where `nand_we_n` rises in a command cycle, `nand_ready` goes low and stays low for eff(timing[23:19]) clocks. Address cycles do not start this delay.
- R9: Outside the busy delay, `nand_ready` follows `nand_rb` through a two-flop synchronizer: a change is visible two clock edges later.
- R10: With `ce_auto`=1, `nand_ce_n` is low exactly while a cycle is in progress. With `ce_auto`=0, `nand_ce_n` is held low at all times.
- R11: `nand_re_n` is always high. The read-width fields timing[15:8] do not change any phase length.
- R12: During reset and right after it, `host_ready`=1, `nand_ready`=0, `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=`nand_ale`=0 and `nand_ce_n`=1 (with `ce_auto`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write request, held until accepted |
| host_addr | input | 1 | 0 = command byte, 1 = address byte |
| host_data | input | DW | Byte to place on the flash bus |
| timing | input | 26 | Packed phase lengths (fields as in R3 to R11) |
| ce_auto | input | 1 | 1 = block drives chip enable, 0 = chip enable held active |
| nand_rb | input | 1 | Flash ready/busy, high when ready |
| host_ready | output | 1 | Block can accept a write |
| nand_ready | output | 1 | Flash ready after the busy delay |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low (held inactive) |
| nand_io | output | DW | Flash I/O bus |

## Verification
The cycle is tried with four timing words:
- a mid-range word, which separates the four phase counters from each other;
- a word with maximal fields, which exposes truncated counter widths;
- an all-zero word, which checks the zero-means-one rule;
- a word with only the read fields set, which shows those fields have no effect.

The bench runs command and address bytes, including 0xFF, back to back. This distinguishes latch-line selection and checks that the busy delay starts only after a command. It also holds a second write on the request line to show that the write is deferred and not lost. Finally, it runs the ready/busy input low and high to expose a missing or extra synchronizer stage, and it runs both chip-enable modes.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_addr,
  input  logic [DW-1:0] host_data,
  input  logic [25:0]   timing,
  input  logic          ce_auto,
  input  logic          nand_rb,
  output logic          host_ready,
  output logic          nand_ready,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_io
);
  localparam int CW = 5;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TURN} st_t;

  st_t           st;
  logic [CW-1:0] cnt, bcnt;
  logic [3:0]    t_wl, t_wh;
  logic [2:0]    t_ta;
  logic [4:0]    t_bd;
  logic          is_addr;
  logic [DW-1:0] io_q;
  logic [1:0]    rb_s;
  logic          unused_rd;

  assign unused_rd = ^timing[15:8];

  function automatic logic [CW-1:0] last(input logic [CW-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bcnt    <= '0;
      t_wl    <= '0;
      t_wh    <= '0;
      t_ta    <= '0;
      t_bd    <= '0;
      is_addr <= 1'b0;
      io_q    <= '0;
      rb_s    <= '0;
    end else begin
      rb_s <= {rb_s[0], nand_rb};
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      case (st)
        S_IDLE: if (host_wr) begin
          t_wl    <= timing[3:0];
          t_wh    <= timing[7:4];
          t_ta    <= timing[18:16];
          t_bd    <= timing[23:19];
          is_addr <= host_addr;
          io_q    <= host_data;
          cnt     <= last({3'b0, timing[25:24]});
          st      <= S_LEAD;
        end
        S_LEAD: if (cnt == '0) begin
          cnt <= last({1'b0, t_wl});
          st  <= S_LOW;
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt == '0) begin
          cnt <= last({1'b0, t_wh});
          st  <= S_HIGH;
          if (!is_addr) bcnt <= (t_bd == '0) ? 5'd1 : t_bd;
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt == '0) begin
          cnt <= last({2'b0, t_ta});
          st  <= S_TURN;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic latch;
  assign latch      = (st == S_LEAD) || (st == S_LOW) || (st == S_HIGH);
  assign host_ready = (st == S_IDLE);
  assign nand_ce_n  = ce_auto ? (st == S_IDLE) : 1'b0;
  assign nand_cle   = latch && !is_addr;
  assign nand_ale   = latch && is_addr;
  assign nand_we_n  = (st != S_LOW);
  assign nand_re_n  = 1'b1;
  assign nand_io    = io_q;
  assign nand_ready = (bcnt == '0) && rb_s[1];
endmodule

module nand_cycle_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_auto,
  input logic          host_ready,
  input logic          nand_ready,
  input logic          nand_ce_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic [DW-1:0] nand_io
);
  a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r4_strobe_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> (nand_cle || nand_ale));
  a_r4_io_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |=> $stable(nand_io));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (nand_we_n && !nand_cle && !nand_ale));
  a_r8_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) && nand_cle) |-> !nand_ready);
  a_r10_ce_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_auto |-> !nand_ce_n);
  a_r10_ce_active: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !nand_ce_n);
  a_r11_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re_n);
endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/nand_cycle_seq_tb.sv
module nand_cycle_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0, host_addr = 1'b0, ce_auto = 1'b1, nand_rb = 1'b1;
  logic [7:0] host_data = '0;
  logic [25:0] timing = '0;
  logic host_ready, nand_ready, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0] nand_io;

  int n_cmp = 0, n_bad = 0;

  nand_cycle_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [25:0] mk(input int ce, wl, wh, ta, bd, rd);
    return {ce[1:0], bd[4:0], ta[2:0], rd[7:0], wh[3:0], wl[3:0]};
  endfunction

  function automatic int eff(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // monitor: busy-delay length, strobe-rise log, read strobe, address-cycle ready
  logic prev_we = 1'b1;
  bit measuring = 0;
  int busy_len = 0, last_busy = -1, log_n = 0;
  logic [7:0] log_io [0:15];
  logic log_cle [0:15];
  bit re_low_seen = 0, addr_busy_seen = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_re_n) re_low_seen = 1;
      if (nand_ale && !nand_ready) addr_busy_seen = 1;
      if (!prev_we && nand_we_n) begin
        if (log_n < 16) begin
          log_io[log_n] = nand_io;
          log_cle[log_n] = nand_cle;
        end
        log_n++;
        if (nand_cle) begin
          measuring = 1;
          busy_len = 0;
        end
      end
      if (measuring) begin
        if (!nand_ready) busy_len++;
        else begin
          measuring = 0;
          last_busy = busy_len;
        end
      end
      prev_we = nand_we_n;
    end
  end

  task automatic do_cycle(input bit a, input logic [7:0] d, input int ece, ewl, ewh, eta,
                          input string tag);
    int n_ce = 0, n_low = 0, n_high = 0, n_ta = 0, guard = 0;
    bit seen_low = 0, lines_ok = 1;
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_wr = 1'b0;
    while (!host_ready && guard < 200) begin
      guard++;
      if (ce_auto && nand_ce_n) lines_ok = 0;
      if (!nand_we_n) begin
        n_low++; seen_low = 1;
      end else if (nand_cle || nand_ale) begin
        if (seen_low) n_high++; else n_ce++;
      end else n_ta++;
      if (nand_cle || nand_ale)
        if (nand_cle != !a || nand_ale != a || nand_io != d) lines_ok = 0;
      @(negedge clk);
    end
    chk(lines_ok, a ? {tag, " R2 latch/data"} : {tag, " R1 latch/data"}, lines_ok, 1);
    chk(n_ce == ece, {tag, " R3 lead"}, n_ce, ece);
    chk(n_low == ewl, {tag, " R4 strobe low"}, n_low, ewl);
    chk(n_high == ewh, {tag, " R4 strobe high"}, n_high, ewh);
    chk(n_ta == eta, {tag, " R5 turnaround"}, n_ta, eta);
  endtask

  task automatic t_reset;
    chk(host_ready && !nand_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale && nand_ce_n,
        "R12 in reset", 0, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready && nand_we_n && !nand_cle && !nand_ale && nand_ce_n, "R12 after reset", 0, 1);
    chk(!nand_ready, "R9 one sync stage", nand_ready, 0);
    @(negedge clk);
    chk(nand_ready, "R9 two sync stages", nand_ready, 1);
  endtask

  task automatic t_cmd_mid;
    timing = mk(2, 3, 2, 4, 6, 0);
    do_cycle(0, 8'h00, 2, 3, 2, 4, "cmd mid");
    repeat (20) @(negedge clk);
    chk(last_busy == 6, "R8 busy delay mid", last_busy, 6);
  endtask

  task automatic t_cmd_reset_max;
    timing = mk(3, 15, 9, 7, 31, 0);
    do_cycle(0, 8'hFF, 3, 15, 9, 7, "cmd FF max");
    repeat (40) @(negedge clk);
    chk(last_busy == 31, "R8 busy delay max", last_busy, 31);
  endtask

  task automatic t_zero;
    timing = '0;
    addr_busy_seen = 0;
    do_cycle(1, 8'h5A, 1, 1, 1, 1, "addr zero R6");
    chk(!addr_busy_seen, "R8 address starts no delay", addr_busy_seen, 0);
    do_cycle(0, 8'h30, 1, 1, 1, 1, "cmd zero R6");
    repeat (5) @(negedge clk);
    chk(last_busy == 1, "R6 zero busy field", last_busy, 1);
  endtask

  task automatic t_read_fields;
    timing = mk(1, 2, 3, 1, 1, 8'hFF);
    re_low_seen = 0;
    do_cycle(1, 8'hA5, 1, 2, 3, 1, "read fields R11");
    chk(!re_low_seen, "R11 read strobe idle", re_low_seen, 0);
  endtask

  task automatic t_backpressure;
    int base, guard = 0;
    timing = mk(1, 2, 2, 2, 2, 0);
    repeat (5) @(negedge clk);
    base = log_n;
    @(negedge clk);
    host_wr = 1'b1; host_addr = 1'b0; host_data = 8'h80;
    @(negedge clk);
    chk(!host_ready, "R7 busy during cycle", host_ready, 0);
    host_addr = 1'b1; host_data = 8'h3C;
    while (!host_ready && guard < 100) begin guard++; @(negedge clk); end
    @(negedge clk);
    host_wr = 1'b0;
    guard = 0;
    while (!host_ready && guard < 100) begin guard++; @(negedge clk); end
    chk(log_n - base == 2, "R7 both writes issued", log_n - base, 2);
    chk(log_io[base] == 8'h80 && log_cle[base], "R7 first in order", log_io[base], 8'h80);
    chk(log_io[base+1] == 8'h3C && !log_cle[base+1], "R7 second in order", log_io[base+1], 8'h3C);
  endtask

  task automatic t_rb;
    timing = mk(1, 1, 1, 1, 3, 0);
    nand_rb = 1'b0;
    do_cycle(0, 8'h70, 1, 1, 1, 1, "cmd rb");
    repeat (10) @(negedge clk);
    chk(!nand_ready, "R9 follows busy flash", nand_ready, 0);
    nand_rb = 1'b1;
    @(negedge clk);
    chk(!nand_ready, "R9 rise after one edge", nand_ready, 0);
    @(negedge clk);
    chk(nand_ready, "R9 rise after two edges", nand_ready, 1);
  endtask

  task automatic t_ce_mode;
    bit ce_high = 0;
    ce_auto = 1'b0;
    @(negedge clk);
    chk(!nand_ce_n, "R10 held mode idle", nand_ce_n, 0);
    fork
      do_cycle(1, 8'h11, 1, 1, 1, 1, "ce held");
      repeat (6) begin @(negedge clk); if (nand_ce_n) ce_high = 1; end
    join
    chk(!ce_high, "R10 held mode during cycle", ce_high, 0);
    ce_auto = 1'b1;
    @(negedge clk);
    chk(nand_ce_n, "R10 auto mode idle", nand_ce_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    t_reset();
    t_cmd_mid();
    t_cmd_reset_max();
    t_zero();
    t_read_fields();
    t_backpressure();
    t_rb();
    t_ce_mode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule